// File: doc/BRIEF.md
# Single to half precision converter

This block turns a 32-bit binary floating-point word into the 16-bit half-width encoding of the same value. It rounds to the nearest representable value, and exact ties go to the even neighbour. It maps infinities and NaNs, saturates exponents that are too large to a signed infinity, and produces gradual-underflow subnormals for small magnitudes. It flushes anything smaller still, including every single-width zero or subnormal input, to a zero that keeps the input's sign.

An operand is presented with a valid strobe. The result appears on a register one clock later together with its own valid strobe. A new operand may be given on every cycle. When no operand is presented, the output register keeps its last value.

Top module: `f2h_conv`

## Requirements
- R1: `out_valid_o` is high exactly one clock after `in_valid_i` was sampled high and low otherwise. Reset drives `out_valid_o` to 0 and `out_data_o` to 0x0000.
- R2: Output bit 15 always equals input bit 31 of the operand that produced it.
- R3: An input exponent field (bits 30:23) of 255 gives output exponent field (bits 14:10) of 0x1F and output mantissa input bits 22:13. When input bits 22:0 are nonzero (NaN), output bit 9 is forced to 1. An infinity input gives mantissa 0.
- R4: For input exponent fields 143 to 254, the output is signed infinity (magnitude 0x7C00) with no rounding.
- R5: For input exponent fields 113 to 142, the output exponent field is the input exponent field minus 112. The output mantissa is input bits 22:13, rounded to nearest even: the round bit is input bit 12, the sticky bits are input bits 11:0, and the lowest kept bit is input bit 13.
- R6: A rounding increment carries out of the mantissa into the exponent. 0x477FF000 gives 0x7C00, and 0x387FF000 gives 0x0400.
- R7: For input exponent fields 102 to 112, the significand (1 followed by bits 22:0) is shifted right by 126 minus the exponent field. It is rounded to nearest even with the round bit at position 125 minus the exponent field, and the result is output with exponent field 0.
- R8: Input exponent fields below 102, including zero and single-width subnormal inputs, give signed zero.
- R9: While `in_valid_i` is low, `out_data_o` does not change, whatever `in_data_i` carries.
- R10: Operands presented on consecutive cycles each give a correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand strobe |
| in_data_i | input | 32 | Single-width operand |
| out_valid_o | output | 1 | Result strobe, one cycle after the operand |
| out_data_o | output | 16 | Half-width result |

## Verification
A wrong path choice or rounding decision shows in `out_data_o` in the very cycle its strobe rises, because there is only one register stage. A wrong round bit position in the subnormal path shows only for the exponents 102 to 112, and a lost carry shows only at the boundaries listed in R6, so these values are driven on purpose next to a long random stream. A strobe that drifts from its operand by one cycle misaligns every later comparison in the scoreboard. A data register that loads while idle breaks the hold check in the following idle cycle.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  parameter int IN_EXP_W  = 8;
  parameter int IN_MAN_W  = 23;
  parameter int OUT_EXP_W = 5;
  parameter int OUT_MAN_W = 10;

  localparam int IN_W       = 1 + IN_EXP_W + IN_MAN_W;
  localparam int OUT_W      = 1 + OUT_EXP_W + OUT_MAN_W;
  localparam int OUT_MAG_W  = OUT_W - 1;
  localparam int IN_BIAS    = 2 ** (IN_EXP_W - 1) - 1;
  localparam int OUT_BIAS   = 2 ** (OUT_EXP_W - 1) - 1;
  localparam int BIAS_DIFF  = IN_BIAS - OUT_BIAS;
  localparam int DROP_W     = IN_MAN_W - OUT_MAN_W;
  localparam int SIG_W      = IN_MAN_W + 1;
  localparam int SH_BASE    = DROP_W + 1 + BIAS_DIFF;
  localparam int SUB_MIN_EXP = SH_BASE - SIG_W;
  localparam int OVF_EXP    = BIAS_DIFF + 2 ** OUT_EXP_W - 1;
  localparam int SH_W       = IN_EXP_W + 1;

  typedef enum logic [2:0] {
    PATH_ZERO,
    PATH_SUB,
    PATH_NORM,
    PATH_OVF,
    PATH_SPEC
  } path_e;

  // nearest-even increment decision
  function automatic logic rne_up(input logic lsb, input logic rb, input logic sticky);
    return rb & (sticky | lsb);
  endfunction
endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
  import f2h_pkg::*;
(
  input  logic [IN_EXP_W-1:0] exp_i,
  output path_e               path_o,
  output logic [SH_W-1:0]     sh_o
);
  always_comb begin
    if (exp_i == '1)                               path_o = PATH_SPEC;
    else if (exp_i >= IN_EXP_W'(OVF_EXP))          path_o = PATH_OVF;
    else if (exp_i > IN_EXP_W'(BIAS_DIFF))         path_o = PATH_NORM;
    else if (exp_i >= IN_EXP_W'(SUB_MIN_EXP))      path_o = PATH_SUB;
    else                                           path_o = PATH_ZERO;
  end

  // only meaningful on the subnormal path
  assign sh_o = SH_W'(SH_BASE) - SH_W'(exp_i);
endmodule

// File: rtl/f2h_norm_path.sv
module f2h_norm_path
  import f2h_pkg::*;
(
  input  logic [IN_EXP_W-1:0]  exp_i,
  input  logic [IN_MAN_W-1:0]  man_i,
  output logic [OUT_MAG_W-1:0] mag_o
);
  logic [IN_EXP_W-1:0]  exp_d;
  logic [OUT_MAG_W-1:0] trunc;
  logic                 inc;

  assign exp_d = exp_i - IN_EXP_W'(BIAS_DIFF);
  assign trunc = {exp_d[OUT_EXP_W-1:0], man_i[IN_MAN_W-1 -: OUT_MAN_W]};
  assign inc   = rne_up(man_i[DROP_W], man_i[DROP_W-1], |man_i[DROP_W-2:0]);
  // carry out of the mantissa lands in the exponent field
  assign mag_o = trunc + OUT_MAG_W'(inc);
endmodule

// File: rtl/f2h_sub_path.sv
module f2h_sub_path
  import f2h_pkg::*;
(
  input  logic [IN_MAN_W-1:0]  man_i,
  input  logic [SH_W-1:0]      sh_i,
  output logic [OUT_MAG_W-1:0] mag_o
);
  logic [SIG_W-1:0] sig;
  logic [SIG_W-1:0] kept;
  logic [SIG_W-1:0] below;
  logic [SH_W-1:0]  rb_pos;
  logic             rb;
  logic             sticky;
  logic             inc;

  assign sig    = {1'b1, man_i};
  assign rb_pos = sh_i - SH_W'(1);
  assign kept   = sig >> sh_i;

  for (genvar i = 0; i < SIG_W; i++) begin : g_below
    assign below[i] = (SH_W'(i) < rb_pos);
  end

  assign rb     = |(sig & (SIG_W'(1) << rb_pos));
  assign sticky = |(sig & below);
  assign inc    = rne_up(kept[0], rb, sticky);
  assign mag_o  = OUT_MAG_W'(kept) + OUT_MAG_W'(inc);
endmodule

// File: rtl/f2h_special.sv
module f2h_special
  import f2h_pkg::*;
(
  input  logic [IN_MAN_W-1:0]  man_i,
  output logic [OUT_MAG_W-1:0] mag_o
);
  logic [OUT_MAN_W-1:0] quiet;

  assign quiet = (man_i != '0) ? OUT_MAN_W'(1) << (OUT_MAN_W - 1) : '0;
  assign mag_o = {{OUT_EXP_W{1'b1}}, man_i[IN_MAN_W-1 -: OUT_MAN_W] | quiet};
endmodule

// File: rtl/f2h_conv.sv
module f2h_conv
  import f2h_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o
);
  localparam logic [OUT_MAG_W-1:0] INF_MAG = {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};

  logic                 sgn;
  logic [IN_EXP_W-1:0]  exp_f;
  logic [IN_MAN_W-1:0]  man_f;
  path_e                path;
  logic [SH_W-1:0]      sh;
  logic [OUT_MAG_W-1:0] norm_mag, sub_mag, spec_mag, mag;

  assign sgn   = in_data_i[IN_W-1];
  assign exp_f = in_data_i[IN_W-2 -: IN_EXP_W];
  assign man_f = in_data_i[IN_MAN_W-1:0];

  f2h_classify u_cls  (.exp_i(exp_f), .path_o(path), .sh_o(sh));
  f2h_norm_path u_norm (.exp_i(exp_f), .man_i(man_f), .mag_o(norm_mag));
  f2h_sub_path u_sub  (.man_i(man_f), .sh_i(sh), .mag_o(sub_mag));
  f2h_special u_spec  (.man_i(man_f), .mag_o(spec_mag));

  always_comb begin
    unique case (path)
      PATH_SPEC: mag = spec_mag;
      PATH_OVF:  mag = INF_MAG;
      PATH_NORM: mag = norm_mag;
      PATH_SUB:  mag = sub_mag;
      default:   mag = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= {sgn, mag};
    end
  end
endmodule

// File: rtl/f2h_conv_chk.sv
module f2h_conv_chk
  import f2h_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [IN_W-1:0]  in_data_i,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] out_data_o
);
  logic [IN_EXP_W-1:0] e_in;
  logic                man_nz;
  logic                out_is_nan;

  assign e_in       = in_data_i[IN_W-2 -: IN_EXP_W];
  assign man_nz     = |in_data_i[IN_MAN_W-1:0];
  assign out_is_nan = (out_data_o[OUT_W-2 -: OUT_EXP_W] == '1) && |out_data_o[OUT_MAN_W-1:0];

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni && in_valid_i |=> out_valid_o);

  a_r1_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r2_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o[OUT_W-1] == $past(in_data_i[IN_W-1]));

  a_r3_nan_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(e_in == '1 && man_nz) |-> out_is_nan && out_data_o[OUT_MAN_W-1]);

  a_r3_no_false_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(!(e_in == '1 && man_nz)) |-> !out_is_nan);

  a_r4_ovf_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(e_in >= IN_EXP_W'(OVF_EXP) && e_in != '1)
      |-> out_data_o[OUT_MAG_W-1:0] == {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}});

  a_r8_flush_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(e_in < IN_EXP_W'(SUB_MIN_EXP)) |-> out_data_o[OUT_MAG_W-1:0] == '0);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o));
endmodule

bind f2h_conv f2h_conv_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o)
);

// File: tb/tb_f2h_conv.sv
module tb_f2h_conv;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        out_valid_o;
  logic [15:0] out_data_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_out = '0;

  always #2 clk_i = ~clk_i;

  f2h_conv dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );

  function automatic logic [15:0] ref_h(input logic [31:0] x);
    logic s;
    int e, m, q, rem, half, sh;
    s = x[31];
    e = int'(x[30:23]);
    m = int'(x[22:0]);
    if (e == 255) return {s, 5'h1f, 10'(m >> 13) | ((m != 0) ? 10'h200 : 10'h0)};
    if (e - 112 >= 31) return {s, 15'h7c00};
    if (e - 112 <= 0) begin
      if (126 - e > 24) return {s, 15'h0};
      sh   = 126 - e;
      q    = (m + (1 << 23)) >> sh;
      rem  = (m + (1 << 23)) - (q << sh);
      half = 1 << (sh - 1);
    end else begin
      q    = ((e - 112) << 10) + (m >> 13);
      rem  = m & 8191;
      half = 4096;
    end
    if (rem > half || (rem == half && (q % 2) == 1)) q = q + 1;
    return {s, 15'(q)};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] x, input string req);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = x;
    exp_q.push_back(ref_h(x));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      in_data_i  = $urandom;  // R9: ignored while idle
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni) begin
        if (out_valid_o) begin
          if (exp_q.size() == 0) begin
            check("R1 unexpected valid", {15'h0, out_valid_o}, 16'h0);
          end else begin
            check(tag_q.pop_front(), out_data_o, exp_q.pop_front());
          end
        end else begin
          check("R9 hold", out_data_o, last_out);
        end
        last_out = out_data_o;
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 reset valid", {15'h0, out_valid_o}, 16'h0);
    check("R1 reset data", out_data_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    send(32'h0000_0000, "R8 +0");
    send(32'h8000_0000, "R2 R8 -0");
    send(32'h0000_0001, "R8 single subnormal");
    send(32'h3280_0000, "R8 below subnormal range");
    send(32'h7F80_0000, "R3 +inf");
    send(32'hFF80_0000, "R2 R3 -inf");
    send(32'h7F80_0001, "R3 signalling nan");
    send(32'h7FC0_0000, "R3 quiet nan");
    send(32'hFFFF_E000, "R3 nan payload");
    idle(2);
    send(32'h4780_0000, "R4 65536");
    send(32'hC780_0000, "R4 -65536");
    send(32'h7F7F_FFFF, "R4 max single");
    send(32'h477F_E000, "R5 65504");
    send(32'h3F80_0000, "R5 one");
    send(32'h3F80_1000, "R5 tie even");
    send(32'h3F80_3000, "R5 tie odd");
    send(32'h3F80_1001, "R5 above tie");
    send(32'h477F_F000, "R6 65520 to inf");
    send(32'h387F_F000, "R6 sub to normal carry");
    send(32'h3880_0000, "R5 smallest normal");
    send(32'h3380_0000, "R7 smallest subnormal");
    send(32'h3300_0000, "R7 tie to zero");
    send(32'h3300_0001, "R7 above tie");
    send(32'hB3C0_0000, "R7 neg tie odd");
    send(32'h3870_0000, "R7 large subnormal");
    idle(3);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v;
      v = $urandom;
      if (i % 2 == 0) v[30:23] = 8'(95 + ($urandom % 55));
      send(v, "R10 stream");
      if (i % 97 == 0) idle(1 + (i % 3));
    end
    idle(4);
    check("R10 drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    finish_run();
  end
endmodule